// File: doc/BRIEF.md
# Video Display Register Bus Adapter

This block is the register file of a video display controller whose registers are 16 bits wide. It holds the display control register, two framebuffer base-address registers (top field and bottom field) and a 32-bit auxiliary register. The auxiliary register is reached as two halfwords. The block also accepts bus accesses of 8 and 32 bits. A 32-bit access becomes two halfword accesses in the same cycle. A byte read returns one half of a halfword, and a byte write is refused and flagged.

Some writes have side effects. A control write keeps only the defined mode bits. Its self-clearing reset bit sends a one-cycle clear pulse to the interrupt unit. A clear-offset bit in the high half of a framebuffer register forces that register's page-offset flag to zero.

From the stored bases the block computes the effective top-field and bottom-field fetch addresses. Both use the top register's page-offset flag. The beam-position counters come from the timing block through input ports and can be read at two read-only addresses.

Top module: `vi_bus_adapter`

## Requirements
- R1: After reset the control register reads 0x0001 (enable bit set). Every other register reads 0. The irq_clr, invalid_wr, ro_warn and bus_rvalid outputs are 0.
- R2: The control register (byte offset 0x00) keeps only bits 0 (enable), 2 (non-interlaced), 3 (stereo), 4 and 5 (latch enables) and 9:8 (format). Bit 1 (reset) and all other bits read back 0.
- R3: A write to the control register with bit 1 set produces irq_clr high for exactly the one cycle after the write. Any other write leaves irq_clr low.
- R4: The framebuffer registers have their high half at 0x04 (top field) and 0x08 (bottom field) and their low half at 0x06 and 0x0A. The high half holds base bits [23:16] in bits 7:0 and the page-offset flag in bit 12. Writing the high half with bit 13 (clear-offset) set stores the flag as 0, whatever bit 12 holds. Bit 13 always reads 0.
- R5: The effective address is the 24-bit base shifted left by 5 when the page-offset flag is set, and the plain base otherwise. The bottom-field address uses the top register's flag and ignores its own.
- R6: A byte read at an even address returns bits 15:8 of the halfword there. A byte read at an odd address returns bits 7:0 of the halfword at the even address below it. Both are zero-extended.
- R7: A byte write changes no register. It raises invalid_wr for exactly the next cycle.
- R8: A 32-bit access ignores address bits 1:0. Data bits 31:16 go to or come from the halfword at 4k. Data bits 15:0 go to or come from the halfword at 4k+2.
- R9: The auxiliary register is at 0x0C (bits 31:16) and 0x0E (bits 15:0). A halfword write replaces only its own half.
- R10: 0x10 reads vbeam_pos and 0x12 reads hbeam_pos. Writes to these addresses are dropped and set the sticky ro_warn flag, which stays set until reset.
- R11: Read data and bus_rvalid appear in the cycle after the request. Unmapped addresses read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 = byte, 1 = halfword, 2 or 3 = 32-bit |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data (a halfword uses bits 15:0) |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| vbeam_pos | input | 16 | Vertical beam position from the timing block |
| hbeam_pos | input | 16 | Horizontal beam position from the timing block |
| ctrl_enable | output | 1 | Control enable bit |
| ctrl_nonint | output | 1 | Non-interlaced mode bit |
| ctrl_stereo | output | 1 | Stereo mode bit |
| ctrl_latch | output | 2 | Latch enable bits |
| ctrl_fmt | output | 2 | Video format field |
| fb_top_addr | output | BASE_W+PAGE_SHIFT | Effective top-field framebuffer address |
| fb_bot_addr | output | BASE_W+PAGE_SHIFT | Effective bottom-field framebuffer address |
| aux_value | output | 32 | Auxiliary register contents |
| irq_clr | output | 1 | One-cycle clear pulse to the interrupt unit |
| invalid_wr | output | 1 | One-cycle flag for a refused byte write |
| ro_warn | output | 1 | Sticky flag: a read-only address was written |

## Verification
The hardest state to reach from the ports is a bottom-field register whose own page-offset flag differs from the top register's flag. Only then does it show whether the bottom address takes the shared flag. The stimulus creates that state directly by setting the flag in one register and clearing it in the other, with the clear-offset bit in play. Random halfword and 32-bit writes then keep both registers moving, so their flags disagree many times. The 32-bit lane split is checked with word accesses whose low two address bits are not zero.

// File: rtl/vi_bus_pkg.sv
package vi_bus_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_WORD2 = 2'd3
   } acc_size_e;

   // halfword byte offsets
   localparam logic [15:0] OFF_CTRL   = 16'h0000;
   localparam logic [15:0] OFF_FBT_HI = 16'h0004;
   localparam logic [15:0] OFF_FBT_LO = 16'h0006;
   localparam logic [15:0] OFF_FBB_HI = 16'h0008;
   localparam logic [15:0] OFF_FBB_LO = 16'h000A;
   localparam logic [15:0] OFF_AUX_HI = 16'h000C;
   localparam logic [15:0] OFF_AUX_LO = 16'h000E;
   localparam logic [15:0] OFF_VBEAM  = 16'h0010;
   localparam logic [15:0] OFF_HBEAM  = 16'h0012;

   // control register bit positions
   localparam int unsigned CB_ENABLE = 0;
   localparam int unsigned CB_RESET  = 1;
   localparam int unsigned CB_NONINT = 2;
   localparam int unsigned CB_STEREO = 3;
   localparam int unsigned CB_LATCH  = 4;
   localparam int unsigned CB_FMT    = 8;
   localparam logic [15:0] CTRL_KEEP = 16'h033D;

   // framebuffer high-half bit positions
   localparam int unsigned FB_POFF = 12;
   localparam int unsigned FB_CLR  = 13;

   typedef struct packed {
      logic       wr;
      logic [15:0] addr;
      logic [15:0] data;
   } lane_t;

   function automatic logic lane_hit(input lane_t ln, input logic [15:0] off);
      return ln.wr && (ln.addr == off);
   endfunction

endpackage

// File: rtl/vi_bus_split.sv
module vi_bus_split
   import vi_bus_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input  logic              req,
   input  logic              we,
   input  logic [1:0]        size,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output lane_t             lane0,
   output lane_t             lane1,
   output logic              is_word,
   output logic              is_byte,
   output logic              byte_wr
);
   logic [15:0] addr16;

   always_comb begin
      addr16  = 16'(addr);
      is_word = size[1];
      is_byte = (size == SZ_BYTE);
      byte_wr = req && we && is_byte;

      lane0.wr   = req && we && !is_byte;
      lane0.addr = is_word ? {addr16[15:2], 2'b00} : {addr16[15:1], 1'b0};
      lane0.data = is_word ? wdata[31:16] : wdata[15:0];

      lane1.wr   = req && we && is_word;
      lane1.addr = {addr16[15:2], 2'b10};
      lane1.data = wdata[15:0];
   end
endmodule

// File: rtl/vi_ctrl_reg.sv
module vi_ctrl_reg
   import vi_bus_pkg::*;
#(
   parameter logic [15:0] RST_VAL = 16'h0001
) (
   input  logic        clk,
   input  logic        rst_n,
   input  lane_t       lane0,
   input  lane_t       lane1,
   output logic [15:0] q,
   output logic        clr_pulse
);
   logic        hit0, hit1, wr;
   logic [15:0] d;

   always_comb begin
      hit0 = lane_hit(lane0, OFF_CTRL);
      hit1 = lane_hit(lane1, OFF_CTRL);
      wr   = hit0 || hit1;
      d    = hit0 ? lane0.data : lane1.data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q         <= RST_VAL & CTRL_KEEP;
         clr_pulse <= 1'b0;
      end else begin
         clr_pulse <= wr && d[CB_RESET];
         if (wr) q <= d & CTRL_KEEP;
      end
   end
endmodule

// File: rtl/vi_fb_reg.sv
module vi_fb_reg
   import vi_bus_pkg::*;
#(
   parameter int unsigned  BASE_W = 24,
   parameter logic [15:0]  OFF_HI = 16'h0004
) (
   input  logic              clk,
   input  logic              rst_n,
   input  lane_t             lane0,
   input  lane_t             lane1,
   output logic [15:0]       rd_hi,
   output logic [15:0]       rd_lo,
   output logic [BASE_W-1:0] base,
   output logic              poff
);
   localparam int unsigned HI_W = BASE_W - 16;
   localparam logic [15:0] OFF_LO = OFF_HI + 16'd2;

   logic [HI_W-1:0] base_hi;
   logic [15:0]     base_lo;
   logic            hh0, hh1, lh0, lh1;
   logic [15:0]     dh, dl;

   always_comb begin
      hh0 = lane_hit(lane0, OFF_HI);
      hh1 = lane_hit(lane1, OFF_HI);
      lh0 = lane_hit(lane0, OFF_LO);
      lh1 = lane_hit(lane1, OFF_LO);
      dh  = hh0 ? lane0.data : lane1.data;
      dl  = lh0 ? lane0.data : lane1.data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_hi <= '0;
         base_lo <= '0;
         poff    <= 1'b0;
      end else begin
         if (hh0 || hh1) begin
            base_hi <= dh[HI_W-1:0];
            poff    <= dh[FB_CLR] ? 1'b0 : dh[FB_POFF];
         end
         if (lh0 || lh1) base_lo <= dl;
      end
   end

   always_comb begin
      rd_hi          = 16'(base_hi);
      rd_hi[FB_POFF] = poff;
      rd_lo          = base_lo;
      base           = {base_hi, base_lo};
   end
endmodule

// File: rtl/vi_bus_adapter.sv
module vi_bus_adapter
   import vi_bus_pkg::*;
#(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned BASE_W     = 24,
   parameter int unsigned PAGE_SHIFT = 5,
   parameter logic [15:0] CTRL_RST   = 16'h0001
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_req,
   input  logic                         bus_we,
   input  logic [1:0]                   bus_size,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [31:0]                  bus_wdata,
   output logic                         bus_rvalid,
   output logic [31:0]                  bus_rdata,
   input  logic [15:0]                  vbeam_pos,
   input  logic [15:0]                  hbeam_pos,
   output logic                         ctrl_enable,
   output logic                         ctrl_nonint,
   output logic                         ctrl_stereo,
   output logic [1:0]                   ctrl_latch,
   output logic [1:0]                   ctrl_fmt,
   output logic [BASE_W+PAGE_SHIFT-1:0] fb_top_addr,
   output logic [BASE_W+PAGE_SHIFT-1:0] fb_bot_addr,
   output logic [31:0]                  aux_value,
   output logic                         irq_clr,
   output logic                         invalid_wr,
   output logic                         ro_warn
);
   localparam int unsigned FA_W  = BASE_W + PAGE_SHIFT;
   localparam int unsigned N_FB  = 2;

   if (ADDR_W < 5 || ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W must lie in 5..16");
   end
   if (BASE_W < 17 || BASE_W > 28) begin : g_bad_base
      $error("BASE_W must lie in 17..28");
   end
   if (PAGE_SHIFT > 8) begin : g_bad_shift
      $error("PAGE_SHIFT must not exceed 8");
   end

   lane_t lane0, lane1;
   logic  is_word, is_byte, byte_wr;

   vi_bus_split #(.ADDR_W(ADDR_W)) u_split (
      .req(bus_req), .we(bus_we), .size(bus_size), .addr(bus_addr),
      .wdata(bus_wdata), .lane0(lane0), .lane1(lane1),
      .is_word(is_word), .is_byte(is_byte), .byte_wr(byte_wr)
   );

   logic [15:0] ctrl_q;
   vi_ctrl_reg #(.RST_VAL(CTRL_RST)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .lane0(lane0), .lane1(lane1),
      .q(ctrl_q), .clr_pulse(irq_clr)
   );

   logic [15:0]       fb_rd_hi [N_FB];
   logic [15:0]       fb_rd_lo [N_FB];
   logic [BASE_W-1:0] fb_base  [N_FB];
   logic              fb_poff  [N_FB];

   for (genvar gi = 0; gi < N_FB; gi++) begin : g_fb
      localparam logic [15:0] OFF = (gi == 0) ? OFF_FBT_HI : OFF_FBB_HI;
      vi_fb_reg #(.BASE_W(BASE_W), .OFF_HI(OFF)) u_fb (
         .clk(clk), .rst_n(rst_n), .lane0(lane0), .lane1(lane1),
         .rd_hi(fb_rd_hi[gi]), .rd_lo(fb_rd_lo[gi]),
         .base(fb_base[gi]), .poff(fb_poff[gi])
      );
   end

   // both fields follow the top register's page-offset flag
   always_comb begin
      fb_top_addr = fb_poff[0] ? (FA_W'(fb_base[0]) << PAGE_SHIFT) : FA_W'(fb_base[0]);
      fb_bot_addr = fb_poff[0] ? (FA_W'(fb_base[1]) << PAGE_SHIFT) : FA_W'(fb_base[1]);
   end

   // auxiliary register, two independent halves
   logic [15:0] aux_q [2];
   for (genvar gh = 0; gh < 2; gh++) begin : g_aux
      localparam logic [15:0] OFF = (gh == 0) ? OFF_AUX_HI : OFF_AUX_LO;
      logic h0, h1;
      always_comb begin
         h0 = lane_hit(lane0, OFF);
         h1 = lane_hit(lane1, OFF);
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          aux_q[gh] <= '0;
         else if (h0 || h1)   aux_q[gh] <= h0 ? lane0.data : lane1.data;
      end
   end
   assign aux_value = {aux_q[0], aux_q[1]};

   // read-only beam addresses
   logic ro_hit;
   always_comb begin
      ro_hit = lane_hit(lane0, OFF_VBEAM) || lane_hit(lane0, OFF_HBEAM) ||
               lane_hit(lane1, OFF_VBEAM) || lane_hit(lane1, OFF_HBEAM);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ro_warn    <= 1'b0;
         invalid_wr <= 1'b0;
      end else begin
         invalid_wr <= byte_wr;
         if (ro_hit) ro_warn <= 1'b1;
      end
   end

   // read path
   function automatic logic [15:0] hw_read(input logic [15:0] a);
      case (a)
         OFF_CTRL:   return ctrl_q;
         OFF_FBT_HI: return fb_rd_hi[0];
         OFF_FBT_LO: return fb_rd_lo[0];
         OFF_FBB_HI: return fb_rd_hi[1];
         OFF_FBB_LO: return fb_rd_lo[1];
         OFF_AUX_HI: return aux_q[0];
         OFF_AUX_LO: return aux_q[1];
         OFF_VBEAM:  return vbeam_pos;
         OFF_HBEAM:  return hbeam_pos;
         default:    return 16'h0000;
      endcase
   endfunction

   logic [15:0] rd0, rd1;
   logic [31:0] rd_next;
   always_comb begin
      rd0 = hw_read(lane0.addr);
      rd1 = hw_read(lane1.addr);
      if (is_word)      rd_next = {rd0, rd1};
      else if (is_byte) rd_next = {24'h0, bus_addr[0] ? rd0[7:0] : rd0[15:8]};
      else              rd_next = {16'h0, rd0};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
      end else begin
         bus_rvalid <= bus_req && !bus_we;
         if (bus_req && !bus_we) bus_rdata <= rd_next;
      end
   end

   always_comb begin
      ctrl_enable = ctrl_q[CB_ENABLE];
      ctrl_nonint = ctrl_q[CB_NONINT];
      ctrl_stereo = ctrl_q[CB_STEREO];
      ctrl_latch  = ctrl_q[CB_LATCH+1:CB_LATCH];
      ctrl_fmt    = ctrl_q[CB_FMT+1:CB_FMT];
   end
endmodule

// File: rtl/vi_bus_adapter_chk.sv
module vi_bus_adapter_chk #(
   parameter int unsigned ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_we,
   input logic [1:0]        bus_size,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              bus_rvalid,
   input logic [31:0]       aux_value,
   input logic              irq_clr,
   input logic              invalid_wr,
   input logic              ro_warn
);
   logic byte_write, ctrl_rst_write;
   always_comb begin
      byte_write     = bus_req && bus_we && (bus_size == 2'd0);
      ctrl_rst_write = bus_req && bus_we && (bus_size == 2'd1) &&
                       ({bus_addr[ADDR_W-1:1], 1'b0} == '0) && bus_wdata[1];
   end

   // R7
   byte_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_write |=> invalid_wr);

   // R7
   no_spurious_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_write |=> !invalid_wr);

   // R7
   byte_write_aux_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_write |=> $stable(aux_value));

   // R3
   ctrl_reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_rst_write |=> irq_clr);

   // R3
   irq_clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && !ctrl_rst_write && !(bus_req && bus_we && bus_size[1])) |=> !irq_clr);

   // R10
   ro_warn_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(ro_warn));

   // R11
   read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we) |=> bus_rvalid);

   // R11
   write_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && !bus_we) |=> !bus_rvalid);
endmodule

bind vi_bus_adapter vi_bus_adapter_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
   .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .bus_rvalid(bus_rvalid), .aux_value(aux_value), .irq_clr(irq_clr),
   .invalid_wr(invalid_wr), .ro_warn(ro_warn)
);

// File: tb/vi_bus_adapter_bench.sv
module vi_bus_adapter_bench;
   localparam int unsigned ADDR_W = 12;
   localparam int unsigned FA_W   = 29;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_req = 1'b0, bus_we = 1'b0;
   logic [1:0]        bus_size = 2'd1;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic              bus_rvalid;
   logic [31:0]       bus_rdata;
   logic [15:0]       vbeam_pos = 16'h0000, hbeam_pos = 16'h0000;
   logic              ctrl_enable, ctrl_nonint, ctrl_stereo;
   logic [1:0]        ctrl_latch, ctrl_fmt;
   logic [FA_W-1:0]   fb_top_addr, fb_bot_addr;
   logic [31:0]       aux_value;
   logic              irq_clr, invalid_wr, ro_warn;

   int unsigned n_chk = 0, n_fail = 0;

   always #10 clk = ~clk;

   vi_bus_adapter u_vi_bus_adapter (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
      .vbeam_pos(vbeam_pos), .hbeam_pos(hbeam_pos),
      .ctrl_enable(ctrl_enable), .ctrl_nonint(ctrl_nonint),
      .ctrl_stereo(ctrl_stereo), .ctrl_latch(ctrl_latch), .ctrl_fmt(ctrl_fmt),
      .fb_top_addr(fb_top_addr), .fb_bot_addr(fb_bot_addr),
      .aux_value(aux_value), .irq_clr(irq_clr), .invalid_wr(invalid_wr),
      .ro_warn(ro_warn)
   );

   // reference state
   logic [15:0] m_ctrl;
   logic [15:0] m_fbh [2];
   logic [15:0] m_fbl [2];
   logic [15:0] m_aux [2];
   logic        m_warn;

   function automatic logic [15:0] m_read(input logic [15:0] a);
      case (a)
         16'h00: return m_ctrl;
         16'h04: return m_fbh[0];
         16'h06: return m_fbl[0];
         16'h08: return m_fbh[1];
         16'h0A: return m_fbl[1];
         16'h0C: return m_aux[0];
         16'h0E: return m_aux[1];
         16'h10: return vbeam_pos;
         16'h12: return hbeam_pos;
         default: return 16'h0;
      endcase
   endfunction

   // returns 1 when the write asks for the interrupt clear
   function automatic logic m_write(input logic [15:0] a, input logic [15:0] d);
      logic clr = 1'b0;
      case (a)
         16'h00: begin m_ctrl = d & 16'h033D; clr = d[1]; end
         16'h04: m_fbh[0] = (d & 16'h00FF) | ((d[13] ? 16'h0 : d) & 16'h1000);
         16'h06: m_fbl[0] = d;
         16'h08: m_fbh[1] = (d & 16'h00FF) | ((d[13] ? 16'h0 : d) & 16'h1000);
         16'h0A: m_fbl[1] = d;
         16'h0C: m_aux[0] = d;
         16'h0E: m_aux[1] = d;
         16'h10, 16'h12: m_warn = 1'b1;
         default: ;
      endcase
      return clr;
   endfunction

   function automatic logic [FA_W-1:0] m_fb(input int i);
      logic [FA_W-1:0] b = FA_W'({m_fbh[i][7:0], m_fbl[i]});
      return m_fbh[0][12] ? (b << 5) : b;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_state();
      chk("R2 ctrl outputs",
          {25'h0, ctrl_fmt, ctrl_latch, ctrl_stereo, ctrl_nonint, ctrl_enable},
          {25'h0, m_ctrl[9:8], m_ctrl[5:4], m_ctrl[3], m_ctrl[2], m_ctrl[0]});
      chk("R5 top address", 32'(fb_top_addr), 32'(m_fb(0)));
      chk("R5 bottom address", 32'(fb_bot_addr), 32'(m_fb(1)));
      chk("R9 aux value", aux_value, {m_aux[0], m_aux[1]});
      chk("R10 ro_warn", 32'(ro_warn), 32'(m_warn));
   endtask

   task automatic op(input logic we, input logic [1:0] sz, input logic [ADDR_W-1:0] a,
                     input logic [31:0] d, input string tag);
      logic [15:0] a16 = 16'(a);
      logic [15:0] l0 = sz[1] ? {a16[15:2], 2'b00} : {a16[15:1], 1'b0};
      logic [15:0] l1 = {a16[15:2], 2'b10};
      logic [31:0] exp_rd = '0;
      logic        exp_clr = 1'b0;
      logic        exp_inv = we && (sz == 2'd0);
      vbeam_pos = 16'($urandom);
      hbeam_pos = 16'($urandom);
      if (!we) begin
         if (sz[1])          exp_rd = {m_read(l0), m_read(l1)};
         else if (sz == 2'd0) begin
            logic [15:0] h = m_read(l0);
            exp_rd = {24'h0, a[0] ? h[7:0] : h[15:8]};
         end else            exp_rd = {16'h0, m_read(l0)};
      end else if (sz[1]) begin
         exp_clr = m_write(l0, d[31:16]);
         exp_clr = m_write(l1, d[15:0]) | exp_clr;
      end else if (sz == 2'd1) begin
         exp_clr = m_write(l0, d[15:0]);
      end
      bus_req = 1'b1; bus_we = we; bus_size = sz; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_req = 1'b0;
      chk({tag, " R11 rvalid"}, 32'(bus_rvalid), 32'(!we));
      if (!we) chk({tag, " R11 read data"}, bus_rdata, exp_rd);
      chk({tag, " R7 invalid_wr"}, 32'(invalid_wr), 32'(exp_inv));
      chk({tag, " R3 irq_clr"}, 32'(irq_clr), 32'(exp_clr));
      check_state();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
      $finish;
   end

   initial begin
      m_ctrl = 16'h0001; m_warn = 1'b0;
      for (int i = 0; i < 2; i++) begin
         m_fbh[i] = '0; m_fbl[i] = '0; m_aux[i] = '0;
      end
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rvalid", 32'(bus_rvalid), 0);
      chk("R1 irq_clr", 32'(irq_clr), 0);
      chk("R1 invalid_wr", 32'(invalid_wr), 0);
      check_state();
      op(0, 2'd1, 12'h000, 0, "R1 ctrl reset value");
      op(0, 2'd2, 12'h004, 0, "R1 fb top");

      // R2 / R3 control register
      op(1, 2'd1, 12'h000, 32'h0000FFFF, "R2 R3 ctrl all ones");
      op(0, 2'd1, 12'h000, 0, "R2 ctrl readback");
      op(1, 2'd1, 12'h000, 32'h00000005, "R3 no reset bit");
      op(1, 2'd2, 12'h000, 32'h00020000, "R3 word reset bit");

      // R4 / R5 framebuffer and shared page-offset flag
      op(1, 2'd1, 12'h006, 32'h00001234, "R5 top lo");
      op(1, 2'd1, 12'h004, 32'h000010AB, "R4 top poff set");
      op(1, 2'd2, 12'h008, 32'h30CD5678, "R4 bottom clr with poff");
      op(0, 2'd1, 12'h008, 0, "R4 clr bit reads zero");
      op(1, 2'd1, 12'h008, 32'h000010CD, "R5 bottom own flag set");
      op(1, 2'd1, 12'h004, 32'h000030AB, "R4 R5 top clr");
      op(0, 2'd1, 12'h004, 0, "R4 top flag cleared");

      // R6 / R7 byte accesses
      op(1, 2'd1, 12'h00C, 32'h0000A55A, "R9 aux hi");
      op(0, 2'd0, 12'h00C, 0, "R6 even byte");
      op(0, 2'd0, 12'h00D, 0, "R6 odd byte");
      op(1, 2'd0, 12'h00C, 32'hFFFFFFFF, "R7 byte write refused");
      op(0, 2'd1, 12'h00C, 0, "R7 aux unchanged");

      // R8 / R9 word split with low address bits set
      op(1, 2'd3, 12'h00F, 32'hDEADBEEF, "R8 word write");
      op(1, 2'd1, 12'h00E, 32'h00001111, "R9 lo only");
      op(0, 2'd2, 12'h00E, 0, "R8 word read");

      // R10 / R11 beam and unmapped
      op(0, 2'd1, 12'h012, 0, "R10 hbeam read");
      op(1, 2'd1, 12'h7F0, 32'h0000FFFF, "R11 unmapped write");
      op(0, 2'd2, 12'h7F0, 0, "R11 unmapped read");
      op(1, 2'd1, 12'h010, 32'h0000BEEF, "R10 beam write");
      op(0, 2'd2, 12'h010, 0, "R10 beam word read");

      // random mix
      for (int k = 0; k < 500; k++) begin
         logic [ADDR_W-1:0] a = ($urandom_range(0, 7) == 0) ? ADDR_W'($urandom)
                                                            : ADDR_W'($urandom_range(0, 21));
         op(1'($urandom), 2'($urandom), a, $urandom, "random");
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule